// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block decides when a small processor subsystem enters and leaves its two low-power states, and it drives the clock gates and power-down requests for those states. Software first writes a 3-bit target code into a mode register. Writing the code does not change anything on its own. The state changes only when the core then raises its wait-for-interrupt strobe. Light sleep stops only the core clock, and any enabled interrupt ends it. Deep sleep stops the core and peripheral clocks and asks the high-speed oscillators and the PLL to power down. It can also power down the flash and the low-speed oscillator. Only a qualified GPIO edge ends deep sleep.

The deep-sleep exit runs in a fixed order. The oscillators restart first, and the block waits a settle count that software programs. It then releases the PLL and waits for lock. If the flash was powered down, it releases the flash and waits for it to report ready. Only after these steps does the core clock return. The low-speed oscillator is kept alive in deep sleep when the real-time clock or the display driver is enabled, unless software explicitly asks for it to be powered down. The reset input works in every state and returns the block to its reset condition.

The sequencer has six states:
- RUN: normal operation.
- SLEEP: light sleep.
- DEEP: deep sleep.
- OSC_UP: oscillator settle.
- PLL_WAIT: PLL lock wait.
- FLASH_WAIT: flash ready wait.

Its transitions are:
- RUN to SLEEP, on the strobe with code 4.
- RUN to DEEP, on the strobe with code 2.
- SLEEP to RUN, on an enabled interrupt.
- DEEP to OSC_UP, on a qualified GPIO edge.
- OSC_UP to PLL_WAIT, when the settle count runs out.
- PLL_WAIT to FLASH_WAIT, on lock, when the flash was powered down.
- PLL_WAIT to RUN, on lock, when the flash was kept on.
- FLASH_WAIT to RUN, on flash ready.

A 2-bit status output reports run (00), sleep (01), deep sleep (10) or waking (11). The status is 11 in all three exit states.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: After reset the status is 00, core and peripheral clock enables are 1, every power-down request is 0, and the mode register holds 0, so a later strobe without a new write leaves the status at 00.
- R2: Writing the mode register without a strobe leaves the status at 00 and all clock enables and power-down requests unchanged.
- R3: A strobe while the mode register holds any code other than 2 or 4 is ignored: the status stays 00 and the core clock stays enabled.
- R4: A strobe with mode code 4 moves to light sleep (status 01) on the next clock. In light sleep the core clock enable is 0, the peripheral clock enable stays 1, and no power-down request is raised.
- R5: In light sleep, a bit set in both the interrupt pending vector and the interrupt enable vector returns the block to run on the next clock. A pending interrupt whose enable bit is 0 has no effect.
- R6: A strobe with mode code 2 moves to deep sleep (status 10) on the next clock. In deep sleep the core and peripheral clock enables are 0, and both the high-speed oscillator and PLL power-down requests are 1.
- R7: During deep sleep and its exit, the low-speed oscillator power-down request is 1 exactly when neither the real-time-clock enable nor the display enable was set at entry, or when the software power-down bit was set at entry. At all other times it is 0.
- R8: During deep sleep the flash power-down request equals the flash power-down enable as sampled at entry.
- R9: Deep sleep is left only on a GPIO pin whose edge-select bit is 1 and whose interrupt-enable bit is 1. The transition on that pin must match its polarity bit (1 means rising, 0 means falling). The pin passes through a synchronizer of SYNC_STAGES flops. Level-configured pins, disabled pins and the interrupt vectors do not wake it.
- R10: On a qualified edge the status becomes 11. The high-speed oscillator request drops to 0 while the PLL request stays 1 for exactly settle_cnt+1 cycles.
- R11: After the settle phase the PLL request drops to 0. The block then holds status 11 with the core clock off until PLL lock is 1. The PLL request is never 0 while the oscillator request is 1.
- R12: When the flash was powered down, the flash request drops to 0 in the cycle after PLL lock, and the return to run waits for flash ready. When the flash was not powered down, PLL lock returns the block to run directly.
- R13: Asserting reset during deep sleep immediately restores the run status, the clock enables and the power-down requests of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock of the controller |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 3 | Mode code written (4 light sleep, 2 deep sleep, others run) |
| wfi_req | input | 1 | Wait-for-interrupt strobe from the core |
| irq_pend | input | NIRQ | Interrupt pending vector |
| irq_en | input | NIRQ | Interrupt enable vector |
| gpio_in | input | NGPIO | Raw GPIO pin levels |
| gpio_edge_sel | input | NGPIO | 1 = pin is edge-sensitive, 0 = level |
| gpio_rise_pol | input | NGPIO | 1 = rising edge, 0 = falling edge |
| gpio_irq_en | input | NGPIO | Per-pin interrupt enable |
| rtc_en | input | 1 | Real-time clock enabled |
| lcd_en | input | 1 | Display driver enabled |
| lsclk_off_req | input | 1 | Software asks to power down the low-speed oscillator anyway |
| flash_pd_en | input | 1 | Power down the flash in deep sleep |
| settle_cnt | input | SETTLE_W | Oscillator settle wait, in cycles minus one |
| pll_lock | input | 1 | PLL lock indication |
| flash_ready | input | 1 | Flash ready indication |
| core_clk_en | output | 1 | Core clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| hs_osc_pd | output | 1 | High-speed oscillator power-down request |
| pll_pd | output | 1 | PLL power-down request |
| flash_pd | output | 1 | Flash power-down request |
| ls_osc_pd | output | 1 | Low-speed oscillator power-down request |
| state_o | output | 2 | Status: 00 run, 01 sleep, 10 deep, 11 waking |

## Verification
Some rules hold on every cycle, and the bound checker covers them:
- The core clock is off outside run.
- The clock and power outputs in each sleep status match that status.
- Without a strobe the block never leaves run.
- Deep sleep only moves on to waking.
- The PLL is never released before the oscillator.
- The flash is never released while the PLL is still held down.
- The low-speed request is confined to deep sleep and waking.

Other behaviour depends on stimulus, so only the bench's scenarios show it:
- The exact settle length.
- The polarity matching of GPIO wake edges.
- That level, disabled and interrupt-vector events leave deep sleep untouched.
- The choice between keeping and dropping the low-speed oscillator.
- Skipping the flash wait.
- Clearing the mode on reset.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    // Width of the software mode register and the two codes that select a sleep depth
    localparam int          MODE_W     = 3;
    localparam logic [2:0]  CODE_LIGHT = 3'd4;
    localparam logic [2:0]  CODE_DEEP  = 3'd2;

    // Sequencer states
    typedef enum logic [2:0] {
        S_RUN        = 3'd0,
        S_SLEEP      = 3'd1,
        S_DEEP       = 3'd2,
        S_OSC_UP     = 3'd3,
        S_PLL_WAIT   = 3'd4,
        S_FLASH_WAIT = 3'd5
    } seq_state_t;

    // Externally visible status code
    typedef enum logic [1:0] {
        STAT_RUN   = 2'b00,
        STAT_SLEEP = 2'b01,
        STAT_DEEP  = 2'b10,
        STAT_WAKE  = 2'b11
    } stat_t;

    // Decoded target of the mode register
    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_LIGHT = 2'd1,
        TGT_DEEP  = 2'd2
    } tgt_t;

    // Clock gates and power-down requests driven by the sequencer
    typedef struct packed {
        logic core_clk_en;
        logic periph_clk_en;
        logic hs_osc_pd;
        logic pll_pd;
        logic flash_pd;
        logic ls_osc_pd;
    } ctl_t;

endpackage

// File: rtl/lpm_mode_reg.sv
module lpm_mode_reg
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    output tgt_t              target
);

    logic [MODE_W-1:0] mode_q;

    // Software-written target code; cleared by reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_en) begin
            mode_q <= wr_data;
        end
    end

    // Only the two sleep codes select a depth; every other code means stay in run
    always_comb begin
        unique case (mode_q)
            CODE_LIGHT: target = TGT_LIGHT;
            CODE_DEEP:  target = TGT_DEEP;
            default:    target = TGT_NONE;
        endcase
    end

endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
    parameter int NIRQ        = 8,
    parameter int NGPIO       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIRQ-1:0]  irq_pend,
    input  logic [NIRQ-1:0]  irq_en,
    input  logic [NGPIO-1:0] gpio_in,
    input  logic [NGPIO-1:0] gpio_edge_sel,
    input  logic [NGPIO-1:0] gpio_rise_pol,
    input  logic [NGPIO-1:0] gpio_irq_en,
    output logic             light_wake,
    output logic             deep_wake
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0][NGPIO-1:0] sync_q;
    logic [NGPIO-1:0]                  prev_q;
    logic [NGPIO-1:0]                  cur;
    logic [NGPIO-1:0]                  rise;
    logic [NGPIO-1:0]                  fall;
    logic [NGPIO-1:0]                  pin_hit;

    // Synchronizer chain followed by one history flop for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            sync_q[0] <= gpio_in;
            for (int s = 1; s < SYNC_STAGES; s++) begin
                sync_q[s] <= sync_q[s-1];
            end
            prev_q <= sync_q[LAST];
        end
    end

    assign cur  = sync_q[LAST];
    assign rise = cur & ~prev_q;
    assign fall = ~cur & prev_q;

    // Per-pin qualification: edge-sensitive, enabled, and the transition matches the polarity
    for (genvar p = 0; p < NGPIO; p++) begin : g_pin
        assign pin_hit[p] = gpio_irq_en[p] & gpio_edge_sel[p] &
                            (gpio_rise_pol[p] ? rise[p] : fall[p]);
    end

    assign deep_wake  = |pin_hit;
    assign light_wake = |(irq_pend & irq_en);

endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                dec,
    input  logic [SETTLE_W-1:0] load_val,
    output logic                done
);

    logic [SETTLE_W-1:0] cnt_q;

    // Loaded on the wake edge, counted down once per settle cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/lpm_seq_fsm.sv
module lpm_seq_fsm
    import lpm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wfi_req,
    input  tgt_t  target,
    input  logic  light_wake,
    input  logic  deep_wake,
    input  logic  tmr_done,
    input  logic  pll_lock,
    input  logic  flash_ready,
    input  logic  rtc_en,
    input  logic  lcd_en,
    input  logic  lsclk_off_req,
    input  logic  flash_pd_en,
    output logic  tmr_load,
    output logic  tmr_dec,
    output ctl_t  ctl,
    output stat_t status
);

    seq_state_t state_q, state_d;
    logic       ls_off_q;
    logic       fl_off_q;
    logic       enter_deep;

    assign enter_deep = (state_q == S_RUN) && wfi_req && (target == TGT_DEEP);

    // State register plus the power choices captured at deep-sleep entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_RUN;
            ls_off_q <= 1'b0;
            fl_off_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (enter_deep) begin
                ls_off_q <= ~(rtc_en | lcd_en) | lsclk_off_req;
                fl_off_q <= flash_pd_en;
            end
        end
    end

    // Next-state logic and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;
        unique case (state_q)
            S_RUN: begin
                if (wfi_req) begin
                    unique case (target)
                        TGT_LIGHT: state_d = S_SLEEP;
                        TGT_DEEP:  state_d = S_DEEP;
                        default:   state_d = S_RUN;
                    endcase
                end
            end
            S_SLEEP: begin
                if (light_wake) begin
                    state_d = S_RUN;
                end
            end
            S_DEEP: begin
                if (deep_wake) begin
                    state_d  = S_OSC_UP;
                    tmr_load = 1'b1;
                end
            end
            S_OSC_UP: begin
                if (tmr_done) begin
                    state_d = S_PLL_WAIT;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            S_PLL_WAIT: begin
                if (pll_lock) begin
                    state_d = fl_off_q ? S_FLASH_WAIT : S_RUN;
                end
            end
            S_FLASH_WAIT: begin
                if (flash_ready) begin
                    state_d = S_RUN;
                end
            end
            default: state_d = S_RUN;
        endcase
    end

    // Moore outputs from the state register
    always_comb begin
        ctl    = '0;
        status = STAT_RUN;
        unique case (state_q)
            S_RUN: begin
                ctl.core_clk_en   = 1'b1;
                ctl.periph_clk_en = 1'b1;
                status            = STAT_RUN;
            end
            S_SLEEP: begin
                ctl.periph_clk_en = 1'b1;
                status            = STAT_SLEEP;
            end
            S_DEEP: begin
                ctl.hs_osc_pd = 1'b1;
                ctl.pll_pd    = 1'b1;
                ctl.flash_pd  = fl_off_q;
                ctl.ls_osc_pd = ls_off_q;
                status        = STAT_DEEP;
            end
            S_OSC_UP: begin
                ctl.pll_pd    = 1'b1;
                ctl.flash_pd  = fl_off_q;
                ctl.ls_osc_pd = ls_off_q;
                status        = STAT_WAKE;
            end
            S_PLL_WAIT: begin
                ctl.flash_pd  = fl_off_q;
                ctl.ls_osc_pd = ls_off_q;
                status        = STAT_WAKE;
            end
            S_FLASH_WAIT: begin
                ctl.ls_osc_pd = ls_off_q;
                status        = STAT_WAKE;
            end
            default: begin
                ctl.core_clk_en   = 1'b1;
                ctl.periph_clk_en = 1'b1;
                status            = STAT_RUN;
            end
        endcase
    end

endmodule

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl
    import lpm_pkg::*;
#(
    parameter int NIRQ        = 8,
    parameter int NGPIO       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_wr,
    input  logic [2:0]          mode_wdata,
    input  logic                wfi_req,
    input  logic [NIRQ-1:0]     irq_pend,
    input  logic [NIRQ-1:0]     irq_en,
    input  logic [NGPIO-1:0]    gpio_in,
    input  logic [NGPIO-1:0]    gpio_edge_sel,
    input  logic [NGPIO-1:0]    gpio_rise_pol,
    input  logic [NGPIO-1:0]    gpio_irq_en,
    input  logic                rtc_en,
    input  logic                lcd_en,
    input  logic                lsclk_off_req,
    input  logic                flash_pd_en,
    input  logic [SETTLE_W-1:0] settle_cnt,
    input  logic                pll_lock,
    input  logic                flash_ready,
    output logic                core_clk_en,
    output logic                periph_clk_en,
    output logic                hs_osc_pd,
    output logic                pll_pd,
    output logic                flash_pd,
    output logic                ls_osc_pd,
    output logic [1:0]          state_o
);

    tgt_t  target;
    logic  light_wake;
    logic  deep_wake;
    logic  tmr_load;
    logic  tmr_dec;
    logic  tmr_done;
    ctl_t  ctl;
    stat_t status;

    lpm_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr),
        .wr_data (mode_wdata),
        .target  (target)
    );

    lpm_wake_qual #(
        .NIRQ        (NIRQ),
        .NGPIO       (NGPIO),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_wake (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_pend      (irq_pend),
        .irq_en        (irq_en),
        .gpio_in       (gpio_in),
        .gpio_edge_sel (gpio_edge_sel),
        .gpio_rise_pol (gpio_rise_pol),
        .gpio_irq_en   (gpio_irq_en),
        .light_wake    (light_wake),
        .deep_wake     (deep_wake)
    );

    lpm_settle_timer #(
        .SETTLE_W (SETTLE_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .dec      (tmr_dec),
        .load_val (settle_cnt),
        .done     (tmr_done)
    );

    lpm_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wfi_req       (wfi_req),
        .target        (target),
        .light_wake    (light_wake),
        .deep_wake     (deep_wake),
        .tmr_done      (tmr_done),
        .pll_lock      (pll_lock),
        .flash_ready   (flash_ready),
        .rtc_en        (rtc_en),
        .lcd_en        (lcd_en),
        .lsclk_off_req (lsclk_off_req),
        .flash_pd_en   (flash_pd_en),
        .tmr_load      (tmr_load),
        .tmr_dec       (tmr_dec),
        .ctl           (ctl),
        .status        (status)
    );

    assign core_clk_en   = ctl.core_clk_en;
    assign periph_clk_en = ctl.periph_clk_en;
    assign hs_osc_pd     = ctl.hs_osc_pd;
    assign pll_pd        = ctl.pll_pd;
    assign flash_pd      = ctl.flash_pd;
    assign ls_osc_pd     = ctl.ls_osc_pd;
    assign state_o       = status;

endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk
    import lpm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wfi_req,
    input logic       core_clk_en,
    input logic       periph_clk_en,
    input logic       hs_osc_pd,
    input logic       pll_pd,
    input logic       flash_pd,
    input logic       ls_osc_pd,
    input logic [1:0] state_o
);

    // R2
    no_wfi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == STAT_RUN && !wfi_req) |=> (state_o == STAT_RUN));

    // R4
    sleep_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == STAT_SLEEP) |-> (!core_clk_en && periph_clk_en && !hs_osc_pd && !pll_pd && !flash_pd));

    // R6
    deep_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == STAT_DEEP) |-> (!core_clk_en && !periph_clk_en && hs_osc_pd && pll_pd));

    // R11
    core_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != STAT_RUN) |-> !core_clk_en);

    // R9
    deep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == STAT_DEEP) |=> (state_o == STAT_DEEP || state_o == STAT_WAKE));

    // R11
    pll_after_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_pd |-> !hs_osc_pd);

    // R12
    flash_after_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_pd) |-> !pll_pd);

    // R7
    ls_pd_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_osc_pd |-> (state_o == STAT_DEEP || state_o == STAT_WAKE));

endmodule

bind lpm_seq_ctrl lpm_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wfi_req       (wfi_req),
    .core_clk_en   (core_clk_en),
    .periph_clk_en (periph_clk_en),
    .hs_osc_pd     (hs_osc_pd),
    .pll_pd        (pll_pd),
    .flash_pd      (flash_pd),
    .ls_osc_pd     (ls_osc_pd),
    .state_o       (state_o)
);

// File: tb/sim_lpm_seq_ctrl.sv
module sim_lpm_seq_ctrl;

    localparam int NIRQ  = 4;
    localparam int NGPIO = 4;
    localparam int SW    = 8;

    // Packed control word {core, periph, hs, pll, flash, ls}
    localparam int CTL_RUN   = 6'b110000;
    localparam int CTL_SLEEP = 6'b010000;

    logic             clk;
    logic             rst_n;
    logic             mode_wr;
    logic [2:0]       mode_wdata;
    logic             wfi_req;
    logic [NIRQ-1:0]  irq_pend;
    logic [NIRQ-1:0]  irq_en;
    logic [NGPIO-1:0] gpio_in;
    logic [NGPIO-1:0] gpio_edge_sel;
    logic [NGPIO-1:0] gpio_rise_pol;
    logic [NGPIO-1:0] gpio_irq_en;
    logic             rtc_en;
    logic             lcd_en;
    logic             lsclk_off_req;
    logic             flash_pd_en;
    logic [SW-1:0]    settle_cnt;
    logic             pll_lock;
    logic             flash_ready;
    logic             core_clk_en;
    logic             periph_clk_en;
    logic             hs_osc_pd;
    logic             pll_pd;
    logic             flash_pd;
    logic             ls_osc_pd;
    logic [1:0]       state_o;

    lpm_seq_ctrl #(
        .NIRQ (NIRQ), .NGPIO (NGPIO), .SYNC_STAGES (2), .SETTLE_W (SW)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .mode_wr (mode_wr), .mode_wdata (mode_wdata),
        .wfi_req (wfi_req), .irq_pend (irq_pend), .irq_en (irq_en),
        .gpio_in (gpio_in), .gpio_edge_sel (gpio_edge_sel),
        .gpio_rise_pol (gpio_rise_pol), .gpio_irq_en (gpio_irq_en),
        .rtc_en (rtc_en), .lcd_en (lcd_en), .lsclk_off_req (lsclk_off_req),
        .flash_pd_en (flash_pd_en), .settle_cnt (settle_cnt),
        .pll_lock (pll_lock), .flash_ready (flash_ready),
        .core_clk_en (core_clk_en), .periph_clk_en (periph_clk_en),
        .hs_osc_pd (hs_osc_pd), .pll_pd (pll_pd), .flash_pd (flash_pd),
        .ls_osc_pd (ls_osc_pd), .state_o (state_o)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    function automatic int ctl_word();
        return int'({core_clk_en, periph_clk_en, hs_osc_pd, pll_pd, flash_pd, ls_osc_pd});
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_mode(input logic [2:0] v);
        mode_wr = 1'b1; mode_wdata = v;
        tick();
        mode_wr = 1'b0;
    endtask

    task automatic pulse_wfi();
        wfi_req = 1'b1;
        tick();
        wfi_req = 1'b0;
    endtask

    task automatic wait_wake(input string req);
        int i;
        for (i = 0; i < 10; i++) begin
            if (state_o == 2'b11) break;
            tick();
        end
        chk(req, int'(state_o), 3);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick();
        chk("R1 status after reset", int'(state_o), 0);
        chk("R1 outputs after reset", ctl_word(), CTL_RUN);
    endtask

    task automatic t_write_only();
        wr_mode(3'd2);
        tick(3);
        chk("R2 status after write only", int'(state_o), 0);
        chk("R2 outputs after write only", ctl_word(), CTL_RUN);
        wr_mode(3'd4);
        tick(2);
        chk("R2 status after second write", int'(state_o), 0);
    endtask

    task automatic t_bad_mode();
        wr_mode(3'd5);
        pulse_wfi();
        chk("R3 strobe with code 5", int'(state_o), 0);
        chk("R3 core clock stays on", int'(core_clk_en), 1);
        wr_mode(3'd0);
        pulse_wfi();
        chk("R3 strobe with code 0", int'(state_o), 0);
    endtask

    task automatic t_sleep();
        wr_mode(3'd4);
        pulse_wfi();
        chk("R4 status in light sleep", int'(state_o), 1);
        chk("R4 outputs in light sleep", ctl_word(), CTL_SLEEP);
        irq_pend = 4'b0100; irq_en = 4'b0000;
        tick(3);
        chk("R5 disabled interrupt ignored", int'(state_o), 1);
        irq_en = 4'b0100;
        tick();
        chk("R5 enabled interrupt wakes", int'(state_o), 0);
        chk("R5 core clock back", int'(core_clk_en), 1);
        irq_pend = '0; irq_en = '0;
        tick();
    endtask

    task automatic t_deep_flash();
        int n;
        rtc_en = 1'b1; lcd_en = 1'b0; lsclk_off_req = 1'b0;
        flash_pd_en = 1'b1; settle_cnt = 8'd5; pll_lock = 1'b0; flash_ready = 1'b0;
        gpio_edge_sel[0] = 1'b1; gpio_rise_pol[0] = 1'b1; gpio_irq_en[0] = 1'b1;
        wr_mode(3'd2);
        pulse_wfi();
        chk("R6 status in deep sleep", int'(state_o), 2);
        // core0 periph0 hs1 pll1 flash1 ls0
        chk("R6 R7 R8 outputs in deep sleep (rtc on)", ctl_word(), 6'b001110);
        gpio_in[0] = 1'b1;
        wait_wake("R9 rising edge wakes");
        chk("R10 oscillator released", int'(hs_osc_pd), 0);
        n = 0;
        while (state_o == 2'b11 && pll_pd && n < 100) begin
            n++;
            tick();
        end
        chk("R10 settle cycles", n, 6);
        chk("R11 PLL released", int'(pll_pd), 0);
        chk("R11 flash still down", int'(flash_pd), 1);
        tick(3);
        chk("R11 waits for lock", int'(state_o), 3);
        chk("R11 core off while unlocked", int'(core_clk_en), 0);
        pll_lock = 1'b1;
        tick();
        chk("R12 flash released after lock", int'(flash_pd), 0);
        tick(2);
        chk("R12 waits for flash ready", int'(state_o), 3);
        chk("R12 core off before flash ready", int'(core_clk_en), 0);
        flash_ready = 1'b1;
        tick();
        chk("R12 run after flash ready", int'(state_o), 0);
        chk("R12 outputs back to run", ctl_word(), CTL_RUN);
        gpio_in[0] = 1'b0;
        tick(4);
    endtask

    task automatic t_deep_fall_noflash();
        int n;
        rtc_en = 1'b0; lcd_en = 1'b0; lsclk_off_req = 1'b0;
        flash_pd_en = 1'b0; settle_cnt = 8'd0; pll_lock = 1'b0; flash_ready = 1'b0;
        gpio_in[3] = 1'b1;
        gpio_edge_sel[3] = 1'b1; gpio_rise_pol[3] = 1'b0; gpio_irq_en[3] = 1'b1;
        tick(4);
        wr_mode(3'd2);
        pulse_wfi();
        // core0 periph0 hs1 pll1 flash0 ls1
        chk("R7 R8 outputs in deep sleep (rtc and lcd off)", ctl_word(), 6'b001101);
        // Level pin, disabled edge pin, and an enabled interrupt vector bit
        gpio_edge_sel[1] = 1'b0; gpio_irq_en[1] = 1'b1; gpio_in[1] = 1'b1;
        gpio_edge_sel[2] = 1'b1; gpio_rise_pol[2] = 1'b1; gpio_irq_en[2] = 1'b0; gpio_in[2] = 1'b1;
        irq_pend = 4'b0001; irq_en = 4'b0001;
        tick(8);
        chk("R9 level, disabled and vector events ignored", int'(state_o), 2);
        chk("R9 outputs untouched", ctl_word(), 6'b001101);
        irq_pend = '0; irq_en = '0;
        gpio_in[3] = 1'b0;
        wait_wake("R9 falling edge wakes");
        n = 0;
        while (state_o == 2'b11 && pll_pd && n < 100) begin
            n++;
            tick();
        end
        chk("R10 zero settle count", n, 1);
        pll_lock = 1'b1;
        tick();
        chk("R12 flash wait skipped", int'(state_o), 0);
        chk("R12 outputs back to run", ctl_word(), CTL_RUN);
        gpio_in = '0; gpio_edge_sel = '0; gpio_irq_en = '0;
        tick(4);
    endtask

    task automatic t_reset_in_deep();
        rtc_en = 1'b1; lcd_en = 1'b1; lsclk_off_req = 1'b1;
        flash_pd_en = 1'b0; pll_lock = 1'b0;
        wr_mode(3'd2);
        pulse_wfi();
        chk("R7 forced low-speed power-down", int'(ls_osc_pd), 1);
        rst_n = 1'b0;
        tick();
        chk("R13 status under reset", int'(state_o), 0);
        chk("R13 outputs under reset", ctl_word(), CTL_RUN);
        rst_n = 1'b1;
        tick();
        pulse_wfi();
        chk("R1 mode cleared by reset", int'(state_o), 0);
    endtask

    initial begin
        rst_n = 1'b0; mode_wr = 1'b0; mode_wdata = '0; wfi_req = 1'b0;
        irq_pend = '0; irq_en = '0; gpio_in = '0; gpio_edge_sel = '0;
        gpio_rise_pol = '0; gpio_irq_en = '0; rtc_en = 1'b0; lcd_en = 1'b0;
        lsclk_off_req = 1'b0; flash_pd_en = 1'b0; settle_cnt = '0;
        pll_lock = 1'b0; flash_ready = 1'b0;
        t_reset();
        t_write_only();
        t_bad_mode();
        t_sleep();
        t_deep_flash();
        t_deep_fall_noflash();
        t_reset_in_deep();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule